// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block holds the program-counter state of a single-issue, in-order processor whose branches take effect one instruction late. It keeps three registered addresses: the address of the instruction now retiring (`pc`), the next one (`npc`) and the one after that (`nnpc`). For each retired instruction, decode supplies a one-hot control-transfer class, a taken flag, an annul bit, an effective address and the current trap level. From these the sequencer computes the next pair of addresses and shifts the state forward by one instruction. Ordinary branches redirect the second address ahead, so the delay-slot instruction still runs. Annulled branches skip the delay slot. The two return-from-trap flavours restore addresses from a small stack of saved pairs indexed by trap level.

Every update is one arithmetic rule applied to the old `npc`, the effective address or a saved pair. Because of this, a branch placed in the delay slot of another branch needs no special handling. A trap-entry write port saves the current `pc` and `npc` at a chosen level. A combinational read port shows the pair stored at the current trap level. A stall input freezes the addresses and the stack.

Instructions are fixed 4-byte words. After each update, `nnpc` always equals the new `npc` plus 4.

Top module: `dbranch_pc_seq`

## Requirements
- R1: After reset, `pc` = `RESET_VEC`, `npc` = `RESET_VEC`+4, `nnpc` = `RESET_VEC`+8, and every trap-stack entry is zero.
- R2: On an accepted instruction of class bit 0 (plain), class bit 1 or bit 2 (conditional or unconditional branch) that is untaken with annul=0, or class bit 4 (conditional trap) untaken, the new values are `pc`=old `npc`, `npc`=old `npc`+4, `nnpc`=old `npc`+8.
- R3: On class bit 1 taken, class bit 2 taken with annul=0, or class bit 3 (call, return or register jump; the taken flag is ignored), the new values are `pc`=old `npc`, `npc`=`effAddr`, `nnpc`=`effAddr`+4. The delay slot therefore runs before the target.
- R4: On class bit 1 or bit 2, untaken with annul=1, the delay slot is squashed: `pc`=old `npc`+4, `npc`=old `npc`+8, `nnpc`=old `npc`+12.
- R5: On class bit 2 taken with annul=1, or class bit 4 taken, the delay slot never runs: `pc`=`effAddr`, `npc`=`effAddr`+4, `nnpc`=`effAddr`+8.
- R6: Class bit 5 (return past the trapped instruction) gives `pc`=savedNpc[TL] and `npc`=savedNpc[TL]+4. Class bit 6 (re-execute the trapped instruction) gives `pc`=savedPc[TL] and `npc`=savedNpc[TL]. In both cases `nnpc`=new `npc`+4.
- R7: When `stall`=1, or when `instValid`=0, the three addresses keep their values. While `stall`=1, a trap-stack write is also ignored.
- R8: An accepted class vector that is not exactly one-hot (including all zeros) is handled as class bit 0.
- R9: When `trapWr`=1 and `stall`=0, the edge stores the pre-update `pc` and `npc` at level `trapWrLevel`. `savedPc`/`savedNpc` show, combinationally, the entry at `trapLevel`.
- R10: For a `trapLevel` of `TRAP_DEPTH` or above, `savedPc` and `savedNpc` read zero and `tlErr` is 1. Trap returns at such a level use the zero pair. Writes to such a level store nothing.
- R11: A control transfer in the delay slot of another control transfer follows the same rules. A taken branch at `pc` with `npc`=A, issued right after an earlier branch to A, gives `pc`=A and `npc` equal to its own target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freeze addresses and trap stack |
| instValid | input | 1 | A retiring instruction is presented |
| instClass | input | 7 | One-hot control-transfer class |
| taken | input | 1 | Branch or trap condition met |
| annul | input | 1 | Annul bit of the branch |
| effAddr | input | AW | Effective target address |
| trapLevel | input | TL_W | Current trap level (read index) |
| trapWr | input | 1 | Trap-entry write strobe |
| trapWrLevel | input | TL_W | Level written on trap entry |
| pc | output | AW | Address of the current instruction |
| npc | output | AW | Next instruction address |
| nnpc | output | AW | Address after the next |
| savedPc | output | AW | Saved PC at `trapLevel` |
| savedNpc | output | AW | Saved NPC at `trapLevel` |
| tlErr | output | 1 | `trapLevel` is out of range |

## Verification
The three addresses are registered. An instruction accepted at a rising edge therefore shows its results on `pc`, `npc` and `nnpc` right after that same edge. The bench drives at the falling edge, lets one rising edge pass, and compares at the following falling edge against a model updated only at that edge. A trap-stack write also lands at that edge, so the saved pair is read back on the next falling edge. The read port and `tlErr` are combinational in `trapLevel`, so those checks happen in the same half-cycle in which the level changes, with no clock edge in between.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int CLS_W   = 7;
  localparam int C_SEQ   = 0;
  localparam int C_CBR   = 1;
  localparam int C_UBR   = 2;
  localparam int C_JMP   = 3;
  localparam int C_CTRAP = 4;
  localparam int C_DONE  = 5;
  localparam int C_RETRY = 6;

  // source of the value that becomes the new pc
  typedef enum logic [2:0] {
    NSEL_KEEP, NSEL_PLUS4, NSEL_EA, NSEL_TNPC, NSEL_TPC
  } npcSel_e;

  // source of the value that becomes the new npc
  typedef enum logic [2:0] {
    NNSEL_PLUS4, NNSEL_PLUS8, NNSEL_EA, NNSEL_EA4, NNSEL_TNPC4, NNSEL_TNPC
  } nnpcSel_e;

  typedef struct packed {
    logic     advance;
    npcSel_e  npcSel;
    nnpcSel_e nnpcSel;
  } pcStrobe_t;
endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             instValid,
  input  logic [CLS_W-1:0] instClass,
  input  logic             taken,
  input  logic             annul,
  output pcStrobe_t        strb
);

  logic isOneHot;
  assign isOneHot = (instClass != '0) && ((instClass & (instClass - 1'b1)) == '0);

  always_comb begin
    strb.advance = instValid && !stall;
    strb.npcSel  = NSEL_KEEP;
    strb.nnpcSel = NNSEL_PLUS4;
    if (isOneHot) begin
      if (instClass[C_CBR]) begin
        if (taken) begin
          strb.nnpcSel = NNSEL_EA;
        end else if (annul) begin
          strb.npcSel  = NSEL_PLUS4;
          strb.nnpcSel = NNSEL_PLUS8;
        end
      end else if (instClass[C_UBR]) begin
        if (taken && annul) begin
          strb.npcSel  = NSEL_EA;
          strb.nnpcSel = NNSEL_EA4;
        end else if (taken) begin
          strb.nnpcSel = NNSEL_EA;
        end else if (annul) begin
          strb.npcSel  = NSEL_PLUS4;
          strb.nnpcSel = NNSEL_PLUS8;
        end
      end else if (instClass[C_JMP]) begin
        strb.nnpcSel = NNSEL_EA;
      end else if (instClass[C_CTRAP]) begin
        if (taken) begin
          strb.npcSel  = NSEL_EA;
          strb.nnpcSel = NNSEL_EA4;
        end
      end else if (instClass[C_DONE]) begin
        strb.npcSel  = NSEL_TNPC;
        strb.nnpcSel = NNSEL_TNPC4;
      end else if (instClass[C_RETRY]) begin
        strb.npcSel  = NSEL_TPC;
        strb.nnpcSel = NNSEL_TNPC;
      end
    end
  end

  // R8: a class vector that is not one-hot behaves as a plain instruction
  p_bad_class_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && ($countones(instClass) != 1)) |->
      (strb.npcSel == NSEL_KEEP && strb.nnpcSel == NNSEL_PLUS4));

  // R4: an untaken annulled conditional branch skips the slot
  p_annul_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && instClass == CLS_W'(1 << C_CBR) && !taken && annul) |->
      (strb.npcSel == NSEL_PLUS4 && strb.nnpcSel == NNSEL_PLUS8));

  // R7: nothing advances while stalled
  p_stall_no_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !strb.advance);

endmodule

// File: rtl/pcseq_dpath.sv
module pcseq_dpath
  import pcseq_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          TRAP_DEPTH = 4,
  parameter int          TL_W       = 3,
  parameter logic [AW-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  pcStrobe_t       strb,
  input  logic [AW-1:0]   effAddr,
  input  logic [TL_W-1:0] trapLevel,
  input  logic            trapWr,
  input  logic [TL_W-1:0] trapWrLevel,
  output logic [AW-1:0]   pc,
  output logic [AW-1:0]   npc,
  output logic [AW-1:0]   nnpc,
  output logic [AW-1:0]   savedPc,
  output logic [AW-1:0]   savedNpc,
  output logic            tlErr
);

  localparam int            IDX_W   = (TRAP_DEPTH > 1) ? $clog2(TRAP_DEPTH) : 1;
  localparam logic [TL_W:0] DEPTH_V = (TL_W + 1)'(TRAP_DEPTH);
  localparam logic [AW-1:0] WORD    = AW'(4);

  logic [AW-1:0] stkPc  [TRAP_DEPTH];
  logic [AW-1:0] stkNpc [TRAP_DEPTH];

  // trap-stack rows, one writer per level
  for (genvar g = 0; g < TRAP_DEPTH; g++) begin : g_level
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stkPc[g]  <= '0;
        stkNpc[g] <= '0;
      end else if (!stall && trapWr && trapWrLevel == TL_W'(g)) begin
        stkPc[g]  <= pc;
        stkNpc[g] <= npc;
      end
    end
  end

  logic tlOk;
  assign tlOk     = ({1'b0, trapLevel} < DEPTH_V);
  assign tlErr    = !tlOk;
  assign savedPc  = tlOk ? stkPc[trapLevel[IDX_W-1:0]]  : '0;
  assign savedNpc = tlOk ? stkNpc[trapLevel[IDX_W-1:0]] : '0;

  logic [AW-1:0] newPc, newNpc;

  always_comb begin
    unique case (strb.npcSel)
      NSEL_KEEP:  newPc = npc;
      NSEL_PLUS4: newPc = npc + WORD;
      NSEL_EA:    newPc = effAddr;
      NSEL_TNPC:  newPc = savedNpc;
      NSEL_TPC:   newPc = savedPc;
      default:    newPc = npc;
    endcase
    unique case (strb.nnpcSel)
      NNSEL_PLUS4: newNpc = npc + WORD;
      NNSEL_PLUS8: newNpc = npc + 2 * WORD;
      NNSEL_EA:    newNpc = effAddr;
      NNSEL_EA4:   newNpc = effAddr + WORD;
      NNSEL_TNPC4: newNpc = savedNpc + WORD;
      NNSEL_TNPC:  newNpc = savedNpc;
      default:     newNpc = npc + WORD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc   <= RESET_VEC;
      npc  <= RESET_VEC + WORD;
      nnpc <= RESET_VEC + 2 * WORD;
    end else if (strb.advance) begin
      pc   <= newPc;
      npc  <= newNpc;
      nnpc <= newNpc + WORD;
    end
  end

  // R7: a stalled cycle leaves the three addresses alone
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(pc) && $stable(npc) && $stable(nnpc)));

  // R2: a keep-select advance moves the old npc into pc
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.advance && strb.npcSel == NSEL_KEEP) |=> (pc == $past(npc)));

  // R10: an out-of-range level reads as zero
  p_tl_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tlErr |-> (savedPc == '0 && savedNpc == '0));

  // R9: a write at the level being read shows the saved pc next cycle
  p_trap_save_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trapWr && !stall && trapWrLevel == trapLevel && tlOk) |=>
      (trapLevel != $past(trapLevel) || savedPc == $past(pc)));

endmodule

// File: rtl/dbranch_pc_seq.sv
module dbranch_pc_seq
  import pcseq_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            TRAP_DEPTH = 4,
  parameter int            TL_W       = 3,
  parameter logic [AW-1:0] RESET_VEC  = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             instValid,
  input  logic [CLS_W-1:0] instClass,
  input  logic             taken,
  input  logic             annul,
  input  logic [AW-1:0]    effAddr,
  input  logic [TL_W-1:0]  trapLevel,
  input  logic             trapWr,
  input  logic [TL_W-1:0]  trapWrLevel,
  output logic [AW-1:0]    pc,
  output logic [AW-1:0]    npc,
  output logic [AW-1:0]    nnpc,
  output logic [AW-1:0]    savedPc,
  output logic [AW-1:0]    savedNpc,
  output logic             tlErr
);

  pcStrobe_t strb;

  pcseq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .instValid (instValid),
    .instClass (instClass),
    .taken     (taken),
    .annul     (annul),
    .strb      (strb)
  );

  pcseq_dpath #(
    .AW         (AW),
    .TRAP_DEPTH (TRAP_DEPTH),
    .TL_W       (TL_W),
    .RESET_VEC  (RESET_VEC)
  ) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall       (stall),
    .strb        (strb),
    .effAddr     (effAddr),
    .trapLevel   (trapLevel),
    .trapWr      (trapWr),
    .trapWrLevel (trapWrLevel),
    .pc          (pc),
    .npc         (npc),
    .nnpc        (nnpc),
    .savedPc     (savedPc),
    .savedNpc    (savedNpc),
    .tlErr       (tlErr)
  );

endmodule

// File: tb/dbranch_pc_seq_tb_top.sv
`timescale 1ns/1ps
module dbranch_pc_seq_tb_top;
  localparam logic [31:0] VEC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        instValid = 1'b0;
  logic [6:0]  instClass = '0;
  logic        taken = 1'b0;
  logic        annul = 1'b0;
  logic [31:0] effAddr = '0;
  logic [2:0]  trapLevel = '0;
  logic        trapWr = 1'b0;
  logic [2:0]  trapWrLevel = '0;
  logic [31:0] pc, npc, nnpc, savedPc, savedNpc;
  logic        tlErr;

  always #2 clk = ~clk;

  dbranch_pc_seq dut_i (
    .clk(clk), .rst_n(rst_n), .stall(stall), .instValid(instValid),
    .instClass(instClass), .taken(taken), .annul(annul), .effAddr(effAddr),
    .trapLevel(trapLevel), .trapWr(trapWr), .trapWrLevel(trapWrLevel),
    .pc(pc), .npc(npc), .nnpc(nnpc), .savedPc(savedPc), .savedNpc(savedNpc),
    .tlErr(tlErr)
  );

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  logic [31:0] mPc, mNpc, mNnpc;
  logic [31:0] sPc  [4];
  logic [31:0] sNpc [4];

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chkState(input string tag);
    chk(tag, "pc", pc, mPc);
    chk(tag, "npc", npc, mNpc);
    chk(tag, "nnpc", nnpc, mNnpc);
  endtask

  function automatic logic [31:0] rdPc(input logic [2:0] tl);
    return (tl < 3'd4) ? sPc[tl[1:0]] : 32'h0;
  endfunction
  function automatic logic [31:0] rdNpc(input logic [2:0] tl);
    return (tl < 3'd4) ? sNpc[tl[1:0]] : 32'h0;
  endfunction

  function automatic string tagFor(input logic [6:0] c, input logic tk, input logic an);
    if ($countones(c) != 1) return "R8";
    if (c[1]) return tk ? "R3" : (an ? "R4" : "R2");
    if (c[2]) return tk ? (an ? "R5" : "R3") : (an ? "R4" : "R2");
    if (c[3]) return "R3";
    if (c[4]) return tk ? "R5" : "R2";
    if (c[5] || c[6]) return "R6";
    return "R2";
  endfunction

  // model update from the requirements, using values before the edge
  task automatic modelStep(input logic [6:0] c, input logic tk, input logic an,
                           input logic [31:0] ea, input logic [2:0] tl);
    logic [31:0] p, n;
    p = mNpc; n = mNpc + 4;
    if ($countones(c) == 1) begin
      if (c[1]) begin
        if (tk) n = ea;
        else if (an) begin p = mNpc + 4; n = mNpc + 8; end
      end else if (c[2]) begin
        if (tk && an) begin p = ea; n = ea + 4; end
        else if (tk) n = ea;
        else if (an) begin p = mNpc + 4; n = mNpc + 8; end
      end else if (c[3]) n = ea;
      else if (c[4]) begin
        if (tk) begin p = ea; n = ea + 4; end
      end else if (c[5]) begin p = rdNpc(tl); n = rdNpc(tl) + 4; end
      else if (c[6]) begin p = rdPc(tl); n = rdNpc(tl); end
    end
    mPc = p; mNpc = n; mNnpc = n + 4;
  endtask

  task automatic doStep(input logic [6:0] c, input logic tk, input logic an,
                        input logic [31:0] ea, input logic [2:0] tl,
                        input logic vld, input logic stl,
                        input logic wr, input logic [2:0] wrl, input string tag);
    @(negedge clk);
    instClass = c; taken = tk; annul = an; effAddr = ea; trapLevel = tl;
    instValid = vld; stall = stl; trapWr = wr; trapWrLevel = wrl;
    @(posedge clk);
    if (!stl && wr && wrl < 3'd4) begin
      sPc[wrl[1:0]] = mPc; sNpc[wrl[1:0]] = mNpc;
    end
    if (vld && !stl) modelStep(c, tk, an, ea, tl);
    @(negedge clk);
    instValid = 1'b0; trapWr = 1'b0; stall = 1'b0;
    chkState(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin sPc[i] = '0; sNpc[i] = '0; end
    mPc = VEC; mNpc = VEC + 4; mNnpc = VEC + 8;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chkState("R1");
    chk("R1", "savedPc", savedPc, 32'h0);
    chk("R1", "tlErr", {31'b0, tlErr}, 32'h0);

    // R9: fill every level while stepping plain instructions
    for (int l = 0; l < 4; l++) begin
      doStep(7'b0000001, 1'b0, 1'b0, 32'h0, 3'(l), 1'b1, 1'b0, 1'b1, 3'(l), "R2");
      chk("R9", "savedPc", savedPc, sPc[l]);
      chk("R9", "savedNpc", savedNpc, sNpc[l]);
    end
    // R10: out-of-range levels
    for (int l = 4; l < 8; l++) begin
      @(negedge clk); trapLevel = 3'(l); #1;
      chk("R10", "savedPc", savedPc, 32'h0);
      chk("R10", "savedNpc", savedNpc, 32'h0);
      chk("R10", "tlErr", {31'b0, tlErr}, 32'h1);
    end
    // R10: write to an out-of-range level stores nothing
    doStep(7'b0000001, 1'b0, 1'b0, 32'h0, 3'd0, 1'b1, 1'b0, 1'b1, 3'd5, "R10");
    for (int l = 0; l < 4; l++) begin
      @(negedge clk); trapLevel = 3'(l); #1;
      chk("R10", "savedPc kept", savedPc, sPc[l]);
    end

    // sweep of every class, flag and level
    for (int c = 0; c < 7; c++)
      for (int tk = 0; tk < 2; tk++)
        for (int an = 0; an < 2; an++)
          for (int tl = 0; tl < 5; tl++) begin
            logic [6:0] cv;
            logic [31:0] ea;
            cv = 7'(1 << c);
            ea = 32'h0004_0000 + 32'((c * 20 + tk * 10 + an * 5 + tl) * 256);
            doStep(cv, 1'(tk), 1'(an), ea, 3'(tl), 1'b1, 1'b0, 1'b0, 3'd0,
                   tagFor(cv, 1'(tk), 1'(an)));
          end

    // R8: vectors that are not one-hot
    doStep(7'b0000000, 1'b1, 1'b1, 32'h0009_0000, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, "R8");
    doStep(7'b0000110, 1'b1, 1'b1, 32'h0009_1000, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, "R8");
    doStep(7'b1111111, 1'b1, 1'b0, 32'h0009_2000, 3'd1, 1'b1, 1'b0, 1'b0, 3'd0, "R8");
    doStep(7'b0101000, 1'b0, 1'b1, 32'h0009_3000, 3'd2, 1'b1, 1'b0, 1'b0, 3'd0, "R8");

    // R7: no valid, then stall with a write attempt
    doStep(7'b0001000, 1'b1, 1'b0, 32'h000A_0000, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, "R7");
    doStep(7'b0001000, 1'b1, 1'b0, 32'h000A_1000, 3'd2, 1'b1, 1'b1, 1'b1, 3'd2, "R7");
    chk("R7", "savedPc after stalled write", savedPc, sPc[2]);
    chk("R7", "savedNpc after stalled write", savedNpc, sNpc[2]);

    // R11: branch in the delay slot of a branch
    doStep(7'b0001000, 1'b1, 1'b0, 32'h000B_0000, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, "R11");
    doStep(7'b0000010, 1'b1, 1'b0, 32'h000C_0000, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, "R11");
    chk("R11", "pc at first target", pc, 32'h000B_0000);
    chk("R11", "npc at second target", npc, 32'h000C_0000);
    doStep(7'b0000001, 1'b0, 1'b0, 32'h0, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, "R11");
    chk("R11", "pc reaches second target", pc, 32'h000C_0000);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule